// File: doc/BRIEF.md
# Memory-Mapped 32-Line Interrupt Controller

This block gathers up to 32 interrupt request lines into a latched status word and qualifies them with a per-line enable mask. It drives a single request output toward a processor. Software reaches it over a plain word-addressed register bus with byte addresses, a write strobe, a read strobe and registered read data.

Each line is either edge or level sensitive. The choice is fixed at build time by a parameter bit mask; software cannot change it. Enable bits are normally changed atomically through separate set and clear alias addresses, and they can also be overwritten as a whole word. A two-bit master enable gates the output, and only the value 2'b11 lets a request through. The vector address gives software the number of the lowest pending line in a single read.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, status, enable and master enable are zero and irq_o is low. The vector offset reads 0xFFFF_FFFF.
- R2: Registers are selected by byte address, one word each: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master enable. An address with bits [1:0] not zero selects nothing: writes to it are ignored and reads return 0.
- R3: An edge-sensitive line sets its status bit only in the cycle its input goes from 0 to 1. If the input stays high after an acknowledge, the bit stays clear. With the default EDGE_MASK, lines 0 to 15 are edge sensitive.
- R4: A level-sensitive line sets its status bit in every cycle its input is high, so an acknowledge does not clear it while the source stays active. With the default EDGE_MASK, lines 16 to 31 are level sensitive.
- R5: A write to the acknowledge offset clears each status bit whose data bit is 1. If a new event and an acknowledge reach the same bit in the same cycle, the bit ends up set.
- R6: A write to the set-enable offset sets the enable bits where the data is 1. A write to the clear-enable offset clears them. All other enable bits keep their value.
- R7: A write to the enable offset replaces the whole enable word.
- R8: The pending offset reads as status AND enable.
- R9: irq_o is high exactly when some pending bit is 1 and the master-enable field (bits [1:0] at 0x1C) equals 2'b11.
- R10: The vector offset reads the number of the lowest pending line, or 0xFFFF_FFFF when no line is pending.
- R11: The acknowledge, set-enable and clear-enable offsets read as 0. Writes to the status, pending and vector offsets have no effect.
- R12: rdata_o is loaded on the clock edge that samples rd_i high. It holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Interrupt request lines, synchronous to clk_i |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A status bit that is wrongly set or cleared shows up on the next status read. It also reaches irq_o in the same cycle whenever that line is enabled and the master field is 2'b11. A corrupted enable bit changes the pending and vector reads at once, and a broken priority order returns the wrong line number on the first vector read taken while two lines are pending. The bench drives one line held high across an acknowledge, an event that coincides with an acknowledge, and two simultaneous edge events, because these are the cases where a fault in the capture or encoder logic shows up.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENAB   = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam int unsigned MASTER_W = 2;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] status_o
);
  logic [NUM_LINES-1:0] ev;
  logic [NUM_LINES-1:0] stat_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= irq_i[i];
      end
      assign ev[i] = irq_i[i] & ~prev_q;
    end else begin : g_level
      assign ev[i] = irq_i[i];
    end

    // new event wins over acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= ev[i] | (stat_q[i] & ~ack_i[i]);
    end
  end

  assign status_o = stat_q;

  assert_event_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));

  assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/irq_enable.sv
module irq_enable #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned MASTER_W  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic                 master_wr_i,
  input  logic [NUM_LINES-1:0] data_i,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [MASTER_W-1:0]  master_o
);
  logic [NUM_LINES-1:0] en_q;
  logic [MASTER_W-1:0]  mer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      mer_q <= '0;
    end else begin
      if (load_i)     en_q <= data_i;
      else if (set_i) en_q <= en_q | data_i;
      else if (clr_i) en_q <= en_q & ~data_i;
      if (master_wr_i) mer_q <= data_i[MASTER_W-1:0];
    end
  end

  assign enable_o = en_q;
  assign master_o = mer_q;

  assert_set_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((en_q & $past(data_i)) == $past(data_i)) &&
              ((en_q & ~$past(data_i)) == ($past(en_q) & ~$past(data_i))));

  assert_clr_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((en_q & $past(data_i)) == '0) &&
              ((en_q & ~$past(data_i)) == ($past(en_q) & ~$past(data_i))));
endmodule

// File: rtl/irq_vector.sv
module irq_vector #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [DATA_W-1:0]    vec_o
);
  always_comb begin
    vec_o = '1;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = DATA_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  import irq_ctrl_pkg::*;

  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  reg_sel_e             sel;
  logic                 aligned;
  logic [NUM_LINES-1:0] status, enable, pending, ack_mask;
  logic [MASTER_W-1:0]  master;
  logic [DATA_W-1:0]    vec, rd_mux, rdata_q;

  assign sel     = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  assign ack_mask = (wr_i && aligned && sel == SEL_ACK) ? wdata_i[NUM_LINES-1:0] : '0;

  irq_capture #(.NUM_LINES(NUM_LINES), .EDGE_MASK(EDGE_MASK)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .ack_i   (ack_mask),
    .status_o(status)
  );

  irq_enable #(.NUM_LINES(NUM_LINES), .MASTER_W(MASTER_W)) i_enable (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_i && aligned && sel == SEL_ENAB),
    .set_i      (wr_i && aligned && sel == SEL_SETEN),
    .clr_i      (wr_i && aligned && sel == SEL_CLREN),
    .master_wr_i(wr_i && aligned && sel == SEL_MASTER),
    .data_i     (wdata_i[NUM_LINES-1:0]),
    .enable_o   (enable),
    .master_o   (master)
  );

  assign pending = status & enable;

  irq_vector #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) i_vector (
    .pend_i(pending),
    .vec_o (vec)
  );

  assign irq_o = (|pending) && (master == '1);

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (sel)
        SEL_STAT:   rd_mux = DATA_W'(status);
        SEL_PEND:   rd_mux = DATA_W'(pending);
        SEL_ENAB:   rd_mux = DATA_W'(enable);
        SEL_VEC:    rd_mux = vec;
        SEL_MASTER: rd_mux = DATA_W'(master);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_master_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master != '1) |-> !irq_o);

  assert_vec_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec != '1) |-> (pending[vec[LINE_W-1:0]] &&
                     ((pending & ((NUM_LINES'(1) << vec[LINE_W-1:0]) - 1'b1)) == '0)));

  assert_vec_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec == '1) |-> (pending == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_top i_irq_ctrl_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .irq_i  (irq),
    .addr_i (addr),
    .wdata_i(wdata),
    .wr_i   (wr),
    .rd_i   (rd),
    .rdata_o(rdata),
    .irq_o  (irq_out)
  );

  always @(posedge clk) rd_seen <= rd;

  // monitor: compare read data one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s irq_o actual=%b expected=%b", t, irq_out, e);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq[n] = 1'b1;
    @(negedge clk); irq[n] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2 reset values through every offset
    check_irq(1'b0, "R1");
    bus_read(5'h00, 32'h0, "R1 status");
    bus_read(5'h04, 32'h0, "R1 pending");
    bus_read(5'h08, 32'h0, "R1 enable");
    bus_read(5'h18, 32'hFFFF_FFFF, "R1 vector");
    bus_read(5'h1C, 32'h0, "R1 master");

    // R3 edge capture, disabled line not pending
    pulse(3);
    bus_read(5'h00, 32'h8, "R3 edge set");
    bus_read(5'h04, 32'h0, "R8 masked");
    bus_read(5'h18, 32'hFFFF_FFFF, "R10 none");

    // R6 set-enable
    bus_write(5'h10, 32'h0000_0108);
    bus_read(5'h08, 32'h0000_0108, "R6 set");
    bus_read(5'h04, 32'h8, "R8 pending");
    bus_read(5'h18, 32'd3, "R10 vector");
    check_irq(1'b0, "R9 master off");
    bus_write(5'h1C, 32'h1);
    check_irq(1'b0, "R9 master half");
    bus_write(5'h1C, 32'h3);
    check_irq(1'b1, "R9 master on");
    bus_read(5'h1C, 32'h3, "R2 master read");

    // R6 clear-enable
    bus_write(5'h14, 32'h0000_0100);
    bus_read(5'h08, 32'h8, "R6 clear");

    // R3 held edge line does not reassert after ack
    @(negedge clk); irq[5] = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(5'h00, 32'h28, "R3 held");
    bus_write(5'h0C, 32'h20);
    repeat (2) @(negedge clk);
    bus_read(5'h00, 32'h8, "R3 no reassert");
    irq[5] = 1'b0;

    // R4 level line reasserts while high
    @(negedge clk); irq[20] = 1'b1;
    @(negedge clk);
    bus_write(5'h0C, 32'h0010_0000);
    bus_read(5'h00, 32'h0010_0008, "R4 reassert");
    irq[20] = 1'b0;
    bus_write(5'h0C, 32'h0010_0000);
    bus_read(5'h00, 32'h8, "R4 ack after drop");

    // R7 whole-word enable load
    bus_write(5'h08, 32'h0010_0000);
    bus_read(5'h08, 32'h0010_0000, "R7 load");
    check_irq(1'b0, "R9 no pending");
    @(negedge clk); irq[20] = 1'b1;
    @(negedge clk);
    check_irq(1'b1, "R9 level pending");
    bus_read(5'h18, 32'd20, "R10 level vector");
    irq[20] = 1'b0;
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h00, 32'h0, "R5 ack all");
    check_irq(1'b0, "R5 ack all irq");

    // R10 lowest line wins
    bus_write(5'h08, 32'hFFFF_FFFF);
    @(negedge clk); irq[7] = 1'b1; irq[2] = 1'b1;
    @(negedge clk); irq[7] = 1'b0; irq[2] = 1'b0;
    bus_read(5'h18, 32'd2, "R10 lowest");
    bus_write(5'h0C, 32'h4);
    bus_read(5'h18, 32'd7, "R10 next");

    // R5 event and ack same cycle
    @(negedge clk);
    irq[9] = 1'b1; addr = 5'h0C; wdata = 32'h200; wr = 1'b1;
    @(negedge clk);
    irq[9] = 1'b0; wr = 1'b0;
    bus_read(5'h00, 32'h280, "R5 event wins");

    // R11 write-only offsets and ignored writes
    bus_write(5'h00, 32'h0);
    bus_write(5'h04, 32'h0);
    bus_write(5'h18, 32'h0);
    bus_read(5'h00, 32'h280, "R11 ignored writes");
    bus_read(5'h0C, 32'h0, "R11 ack reads 0");
    bus_read(5'h10, 32'h0, "R11 set reads 0");
    bus_read(5'h14, 32'h0, "R11 clr reads 0");

    // R2 misaligned address
    bus_write(5'h09, 32'h0);
    bus_read(5'h08, 32'hFFFF_FFFF, "R2 misaligned write");
    bus_read(5'h09, 32'h0, "R2 misaligned read");

    // R12 hold without strobe
    bus_read(5'h00, 32'h280, "R12 load");
    @(negedge clk); addr = 5'h08;
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 32'h280) begin
      fails++;
      $display("FAIL R12 hold actual=%h expected=%h", rdata, 32'h280);
    end

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule